// File: doc/BRIEF.md
# Dual-Unit Watchdog Counter

The block is a host-programmed watchdog. Software loads a reload value through a small register port. The counter then counts down toward zero, one step per 1 Hz tick in seconds mode, or one step per sixty ticks in minutes mode. The counter is 8 or 16 bits wide, and a parameter selects the width. When the count reaches zero, or when software forces an expiry, the block sets a sticky expiry flag. On the same edge it starts fixed-length pulses on up to three outputs: a keyboard-controller reset request, a generic timeout line and a power-good drop. Each output has its own enable bit.

Software restarts the countdown by writing either byte of the value. Peripheral activity can also restart it, if software has enabled that source: a game-port read strobe, a keyboard interrupt, a mouse interrupt, or a consumer-IR interrupt. The consumer-IR reload takes effect only after a fixed delay of `CIR_DLY` clock cycles.

The controller is a three-state machine:
- `WD_STOP` means the value is zero and the counter is held.
- `WD_RUN` means the counter is counting down.
- `WD_FIRED` means the counter has expired and holds at zero.

The transitions are:
- *arm*: any state goes to `WD_RUN` on a value write with a non-zero result, or on an enabled reload event while the value is non-zero.
- *disarm*: any state goes to `WD_STOP` on a value write whose result is zero.
- *expire*: `WD_RUN` goes to `WD_FIRED` when a decrement takes the count from 1 to 0.
- *force*: any state goes to `WD_FIRED` on a control write with the force bit set.

Top module: `wdog_dual_unit`

## Requirements
- R1: The register addresses are 0 = control, 1 = config, 2 = count low byte and 3 = count high byte.
  - A read strobe at a clock edge loads `reg_rdata` with the addressed register as it was just before that edge.
  - Control reads back as {cir_en(7), mouse_en(6), kbd_en(5), gp_en(4), 0, 0, force(1) reads 0, expired(0)}.
  - Config reads back exactly as written.
  - Addresses 2 and 3 return the live counter.
- R2: A write to address 2 (or address 3) replaces the low (or high) byte of the reload value. It loads the counter with the full new value, clears the minutes prescaler and enters `WD_RUN`.
- R3: A value write whose resulting value is zero enters `WD_STOP`. The counter reads 0, ticks have no effect and no expiry occurs.
- R4: With config bit 7 = 1 (seconds), each tick in `WD_RUN` decrements the counter by one.
- R5: With config bit 7 = 0 (minutes), the counter decrements once every 60 ticks, counted from the latest reload.
- R6: A decrement from 1 to 0 enters `WD_FIRED`. It sets the expired bit (control bit 0, also `fired_o`), and the counter holds at 0.
- R7: The expired bit stays set until a control write has bit 0 = 0. A control write with bit 0 = 1 leaves the bit unchanged.
- R8: A control write with bit 1 = 1 causes an immediate expiry: the counter becomes 0 and the expired bit is set. Bit 1 reads back as 0.
- R9: The game-port read (control bit 4), keyboard (bit 5) and mouse (bit 6) strobes each reload the counter from the reload value when their enable bit is set.
  - A strobe whose enable bit is clear has no effect.
  - No source reloads while the reload value is zero.
- R10: With control bit 7 set, a consumer-IR interrupt reloads the counter exactly `CIR_DLY` cycles later. Clearing bit 7 before that point cancels the pending reload.
- R11: At an expiry edge, `kbd_rst_o` (config bit 6), `tmo_o` (config bit 5) and `pg_drop_o` (config bit 4) each go high for `PULSE_LEN` cycles. Each output pulses only if its bit is set at that edge.
- R12: With `CNT_W` = 8, writes to address 3 are ignored and address 3 reads 0.
- R13: Within one cycle, a value write takes priority over force, force over an event reload, and an event reload over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| gp_rd_stb | input | 1 | Game-port read strobe |
| cir_irq | input | 1 | Consumer-IR interrupt pulse |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| kbd_rst_o | output | 1 | Keyboard reset pulse |
| tmo_o | output | 1 | Timeout pulse |
| pg_drop_o | output | 1 | Power-good drop pulse |
| fired_o | output | 1 | Sticky expired flag |

## Verification
The bench aims at the priority corners:
- A force write together with a reload strobe. A design that let the reload win would miss the expiry.
- A tick together with a reload at a count of one. A design that decremented first would expire spuriously.
- A value write together with a strobe.

Minutes mode is run across a mid-count reload. A prescaler that does not clear would decrement early.

The consumer-IR path is checked twice:
- Once for the exact delay.
- Once for cancellation. A design that ignored the cancel would reload late.

Each pulse output is checked against its own enable, to catch swapped enable bits. The narrow variant is checked for high-byte writes that leak into the counter.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_STOP  = 2'd0,
        WD_RUN   = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_LO   = 2'd2;
    localparam logic [1:0] A_HI   = 2'd3;

    // control register bit positions
    localparam int C_STAT  = 0;
    localparam int C_FORCE = 1;
    localparam int C_GP    = 4;
    localparam int C_KBD   = 5;
    localparam int C_MOUSE = 6;
    localparam int C_CIR   = 7;

    // config register bit positions
    localparam int F_PG    = 4;
    localparam int F_UNIT  = 7;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic tick,
    input  logic unit_sec,
    output logic dec_en
);
    localparam int PRE_W = $clog2(TICKS_PER_MIN);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MIN - 1);

    logic [PRE_W-1:0] pre_q;

    assign dec_en = en & tick & (unit_sec | (pre_q == PRE_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (en && tick && !unit_sec)
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
    end

    // R5: prescaler never leaves its 0..TICKS_PER_MIN-1 range
    assert_pre_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);
endmodule

// File: rtl/wdog_cir_delay.sv
module wdog_cir_delay #(
    parameter int CIR_DLY = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic irq,
    output logic fire
);
    localparam int CD_W = $clog2(CIR_DLY + 1);

    logic [CD_W-1:0] cnt_q;

    assign fire = en & (cnt_q == CD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en)
            cnt_q <= '0;
        else if (irq)
            cnt_q <= CD_W'(CIR_DLY);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CD_W'(1);
    end

    // R10: disabling the source drops any pending delayed reload
    assert_cir_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_o
);
    localparam int PW = $clog2(LEN + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (trig)
            cnt_q <= PW'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - PW'(1);
    end

    assign pulse_o = (cnt_q != '0);

    // R11: an output pulse only starts from an expiry trigger
    assert_pulse_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(trig));
endmodule

// File: rtl/wdog_dual_unit.sv
module wdog_dual_unit
    import wdog_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int PULSE_LEN     = 16,
    parameter int CIR_DLY       = 500000,
    parameter int TICKS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       gp_rd_stb,
    input  logic       cir_irq,
    input  logic       kbd_irq,
    input  logic       mouse_irq,
    output logic       kbd_rst_o,
    output logic       tmo_o,
    output logic       pg_drop_o,
    output logic       fired_o
);
    localparam bit HAS_HI = (CNT_W > 8);
    localparam int N_OUT  = 3;

    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, val_q, val_d, new_val;
    logic [3:0]       en_q;      // {cir, mouse, kbd, gp}
    logic [7:0]       cfg_q;
    logic             status_q;
    logic [7:0]       rdata_q;
    logic [7:0]       cnt_hi;

    logic wr_ctrl, wr_cfg, wr_lo, wr_hi, ld, force_to;
    logic cir_fire, evt, val_nz, dec_en, timeout, clr;
    logic [N_OUT-1:0] pulse_v;

    assign wr_ctrl  = reg_wr & (reg_addr == A_CTRL);
    assign wr_cfg   = reg_wr & (reg_addr == A_CFG);
    assign wr_lo    = reg_wr & (reg_addr == A_LO);
    assign force_to = wr_ctrl & reg_wdata[C_FORCE];

    generate
        if (HAS_HI) begin : g_wide
            assign wr_hi   = reg_wr & (reg_addr == A_HI);
            assign new_val = wr_hi ? {reg_wdata, val_q[7:0]}
                                   : {val_q[CNT_W-1:8], reg_wdata};
            assign cnt_hi  = cnt_q[CNT_W-1:8];
        end else begin : g_narrow
            assign wr_hi   = 1'b0;
            assign new_val = reg_wdata;
            assign cnt_hi  = 8'h00;
        end
    endgenerate

    assign ld     = wr_lo | wr_hi;
    assign val_nz = (val_q != '0);
    assign evt    = (en_q[0] & gp_rd_stb) | (en_q[1] & kbd_irq) |
                    (en_q[2] & mouse_irq) | cir_fire;
    assign clr    = ld | force_to | (evt & val_nz);

    wdog_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(st_q == WD_RUN), .clr(clr),
        .tick(tick_1hz), .unit_sec(cfg_q[F_UNIT]), .dec_en(dec_en));

    wdog_cir_delay #(.CIR_DLY(CIR_DLY)) u_cir (
        .clk(clk), .rst_n(rst_n), .en(en_q[3]), .irq(cir_irq), .fire(cir_fire));

    // next-state: value write > force > event reload > decrement
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        val_d   = val_q;
        timeout = 1'b0;
        if (ld) begin
            val_d = new_val;
            if (new_val == '0) begin
                st_d  = WD_STOP;
                cnt_d = '0;
            end else begin
                st_d  = WD_RUN;
                cnt_d = new_val;
            end
        end else if (force_to) begin
            st_d    = WD_FIRED;
            cnt_d   = '0;
            timeout = 1'b1;
        end else if (evt && val_nz) begin
            st_d  = WD_RUN;
            cnt_d = val_q;
        end else begin
            unique case (st_q)
                WD_RUN: begin
                    if (dec_en) begin
                        cnt_d = cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) begin
                            st_d    = WD_FIRED;
                            timeout = 1'b1;
                        end
                    end
                end
                WD_STOP, WD_FIRED: ;
                default: st_d = WD_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_STOP;
            cnt_q <= '0;
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            val_q <= val_d;
        end
    end

    // register file and read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            cfg_q    <= '0;
            status_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (wr_ctrl) en_q <= reg_wdata[C_CIR:C_GP];
            if (wr_cfg)  cfg_q <= reg_wdata;
            if (timeout)
                status_q <= 1'b1;
            else if (wr_ctrl && !reg_wdata[C_STAT])
                status_q <= 1'b0;
            if (reg_rd) begin
                unique case (reg_addr)
                    A_CTRL: rdata_q <= {en_q, 3'b000, status_q};
                    A_CFG:  rdata_q <= cfg_q;
                    A_LO:   rdata_q <= cnt_q[7:0];
                    A_HI:   rdata_q <= cnt_hi;
                    default: rdata_q <= '0;
                endcase
            end
        end
    end

    // one stretcher per reset-type output, enabled by config bits 4..6
    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_out
            wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
                .clk(clk), .rst_n(rst_n),
                .trig(timeout & cfg_q[F_PG + g]),
                .pulse_o(pulse_v[g]));
        end
    endgenerate

    assign pg_drop_o = pulse_v[0];
    assign tmo_o     = pulse_v[1];
    assign kbd_rst_o = pulse_v[2];
    assign fired_o   = status_q;
    assign reg_rdata = rdata_q;

    assert_stop_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_STOP) |-> (cnt_q == '0));

    assert_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_RUN && !ld && !force_to && !(evt && val_nz)) |=> (cnt_q <= $past(cnt_q)));

    assert_fired_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_FIRED) |-> (cnt_q == '0));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !(wr_ctrl && !reg_wdata[C_STAT])) |=> status_q);

    assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_to && !ld) |=> (st_q == WD_FIRED && status_q && cnt_q == '0));
endmodule

// File: tb/wdog_dual_unit_tb.sv
module wdog_dual_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PL  = 4;
    localparam int CD  = 12;
    localparam int TPM = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 0, reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic gp_rd_stb = 0, cir_irq = 0, kbd_irq = 0, mouse_irq = 0;
    logic [7:0] reg_rdata;
    logic kbd_rst_o, tmo_o, pg_drop_o, fired_o;

    logic b_wr = 0, b_rd = 0;
    logic [1:0] b_addr = 0;
    logic [7:0] b_wdata = 0, b_rdata;
    logic b_kbd, b_tmo, b_pg, b_fired;

    int checks = 0, fails = 0;
    bit mon_on = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_dual_unit #(.CNT_W(16), .PULSE_LEN(PL), .CIR_DLY(CD), .TICKS_PER_MIN(TPM)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gp_rd_stb(gp_rd_stb), .cir_irq(cir_irq), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
        .kbd_rst_o(kbd_rst_o), .tmo_o(tmo_o), .pg_drop_o(pg_drop_o), .fired_o(fired_o));

    wdog_dual_unit #(.CNT_W(8), .PULSE_LEN(PL), .CIR_DLY(CD), .TICKS_PER_MIN(TPM)) dut8_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(1'b0), .reg_wr(b_wr), .reg_rd(b_rd),
        .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(b_rdata),
        .gp_rd_stb(1'b0), .cir_irq(1'b0), .kbd_irq(1'b0), .mouse_irq(1'b0),
        .kbd_rst_o(b_kbd), .tmo_o(b_tmo), .pg_drop_o(b_pg), .fired_o(b_fired));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    int m_st, m_cnt, m_val, m_en, m_stat, m_cfg, m_pre, m_cir, m_rd;
    int m_pc[3];

    always @(posedge clk) begin
        int n_st, n_cnt, n_val, n_pre, n_cir, nv;
        bit ld, frc, fire, ev, dec, tmo, clr;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_val = 0; m_en = 0; m_stat = 0;
            m_cfg = 0; m_pre = 0; m_cir = 0; m_rd = 0;
            for (int i = 0; i < 3; i++) m_pc[i] = 0;
        end else begin
            ld   = reg_wr && (reg_addr == 2 || reg_addr == 3);
            frc  = reg_wr && reg_addr == 0 && reg_wdata[1];
            fire = (m_cir == 1) && (m_en & 8) != 0;
            ev   = ((m_en & 1) && gp_rd_stb) || ((m_en & 2) && kbd_irq) ||
                   ((m_en & 4) && mouse_irq) || fire;
            dec  = (m_st == 1) && tick_1hz && (((m_cfg & 128) != 0) || m_pre == TPM - 1);
            nv   = (reg_addr == 3) ? ((int'(reg_wdata) << 8) | (m_val & 255))
                                   : ((m_val & 'hff00) | int'(reg_wdata));
            n_st = m_st; n_cnt = m_cnt; n_val = m_val; tmo = 0;
            clr  = ld || frc || (ev && m_val != 0);
            if (ld) begin
                n_val = nv;
                if (nv == 0) begin n_st = 0; n_cnt = 0; end
                else begin n_st = 1; n_cnt = nv; end
            end else if (frc) begin
                n_st = 2; n_cnt = 0; tmo = 1;
            end else if (ev && m_val != 0) begin
                n_st = 1; n_cnt = m_val;
            end else if (dec) begin
                n_cnt = m_cnt - 1;
                if (m_cnt == 1) begin n_st = 2; tmo = 1; end
            end
            if (clr) n_pre = 0;
            else if (m_st == 1 && tick_1hz && (m_cfg & 128) == 0)
                n_pre = (m_pre == TPM - 1) ? 0 : m_pre + 1;
            else n_pre = m_pre;
            if ((m_en & 8) == 0) n_cir = 0;
            else if (cir_irq) n_cir = CD;
            else if (m_cir != 0) n_cir = m_cir - 1;
            else n_cir = 0;
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: m_rd = (m_en << 4) | m_stat;
                    2'd1: m_rd = m_cfg;
                    2'd2: m_rd = m_cnt & 255;
                    default: m_rd = (m_cnt >> 8) & 255;
                endcase
            end
            for (int i = 0; i < 3; i++) begin
                if (tmo && ((m_cfg >> (4 + i)) & 1)) m_pc[i] = PL;
                else if (m_pc[i] > 0) m_pc[i] = m_pc[i] - 1;
            end
            if (tmo) m_stat = 1;
            else if (reg_wr && reg_addr == 0 && !reg_wdata[0]) m_stat = 0;
            if (reg_wr && reg_addr == 0) m_en = int'(reg_wdata[7:4]);
            if (reg_wr && reg_addr == 1) m_cfg = int'(reg_wdata);
            m_st = n_st; m_cnt = n_cnt; m_val = n_val; m_pre = n_pre; m_cir = n_cir;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (mon_on && !done) begin
            chk("R6 fired_o", int'(fired_o), m_stat);
            chk("R1 reg_rdata", int'(reg_rdata), m_rd);
            chk("R11 pg_drop_o", int'(pg_drop_o), int'(m_pc[0] != 0));
            chk("R11 tmo_o", int'(tmo_o), int'(m_pc[1] != 0));
            chk("R11 kbd_rst_o", int'(kbd_rst_o), int'(m_pc[2] != 0));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; v = int'(reg_rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1;
            @(negedge clk); tick_1hz = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stb(input int which);
        @(negedge clk);
        gp_rd_stb = (which == 0); kbd_irq = (which == 1);
        mouse_irq = (which == 2); cir_irq = (which == 3);
        @(negedge clk);
        gp_rd_stb = 0; kbd_irq = 0; mouse_irq = 0; cir_irq = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired before the sequence completed");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        chk("R6 reset fired_o", int'(fired_o), 0);
        chk("R11 reset outputs", int'({kbd_rst_o, tmo_o, pg_drop_o}), 0);
        rd(2'd0, v); chk("R1 reset control", v, 0);

        // R1 config readback, R2 value load, R4 seconds countdown
        wr(2'd1, 8'hE5);
        rd(2'd1, v); chk("R1 config readback", v, 'hE5);
        wr(2'd2, 8'd5);
        rd(2'd2, v); chk("R2 loaded count", v, 5);
        ticks(3);
        rd(2'd2, v); chk("R4 after 3 ticks", v, 2);
        ticks(2);
        chk("R6 expired flag", int'(fired_o), 1);
        chk("R11 kbd pulse on", int'(kbd_rst_o), 1);
        chk("R11 pg stays low", int'(pg_drop_o), 0);
        rd(2'd2, v); chk("R6 count held at 0", v, 0);
        rd(2'd0, v); chk("R6 control bit0", v, 'h01);

        // R7 sticky status
        wr(2'd0, 8'h01); chk("R7 write 1 keeps", int'(fired_o), 1);
        wr(2'd0, 8'h00); chk("R7 write 0 clears", int'(fired_o), 0);

        // R3 zero stops
        wr(2'd2, 8'd0);
        ticks(3);
        chk("R3 no expiry when stopped", int'(fired_o), 0);
        rd(2'd2, v); chk("R3 count zero", v, 0);

        // R9 event reloads
        wr(2'd2, 8'd4);
        ticks(2);
        stb(0); stb(1); stb(2);
        rd(2'd2, v); chk("R9 disabled sources ignored", v, 2);
        wr(2'd0, 8'h70);
        stb(0); rd(2'd2, v); chk("R9 game-port reload", v, 4);
        ticks(1); stb(1); rd(2'd2, v); chk("R9 keyboard reload", v, 4);
        ticks(1); stb(2); rd(2'd2, v); chk("R9 mouse reload", v, 4);

        // R13 force beats event reload
        @(negedge clk); reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h72; gp_rd_stb = 1;
        @(negedge clk); reg_wr = 0; gp_rd_stb = 0;
        chk("R13 force over reload", int'(fired_o), 1);
        rd(2'd2, v); chk("R13 count zero after force", v, 0);
        rd(2'd0, v); chk("R8 force bit reads 0", v, 'h71);
        wr(2'd0, 8'h70);
        // R13 value write beats event reload
        @(negedge clk); reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'd9; gp_rd_stb = 1;
        @(negedge clk); reg_wr = 0; gp_rd_stb = 0;
        rd(2'd2, v); chk("R13 value write wins", v, 9);
        // R13 reload beats decrement at count 1
        wr(2'd2, 8'd1);
        @(negedge clk); tick_1hz = 1; gp_rd_stb = 1;
        @(negedge clk); tick_1hz = 0; gp_rd_stb = 0;
        chk("R13 no expiry on reload+tick", int'(fired_o), 0);
        rd(2'd2, v); chk("R13 reloaded to 1", v, 1);
        ticks(1);
        chk("R6 expiry from 1", int'(fired_o), 1);

        // R5 minutes mode with prescaler clear on reload
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h60);
        wr(2'd2, 8'd2);
        ticks(TPM - 1); rd(2'd2, v); chk("R5 before 60th tick", v, 2);
        ticks(1);       rd(2'd2, v); chk("R5 at 60th tick", v, 1);
        stb(0);
        ticks(TPM - 1); rd(2'd2, v); chk("R5 prescaler cleared", v, 2);
        ticks(1);       rd(2'd2, v); chk("R5 first minute", v, 1);
        ticks(TPM);
        chk("R5 expiry in minutes", int'(fired_o), 1);

        // R10 delayed IR reload and cancellation
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h90);
        wr(2'd2, 8'd3);
        ticks(1);
        stb(3); idle(2 * CD);
        rd(2'd2, v); chk("R10 delayed reload", v, 3);
        ticks(1);
        stb(3); wr(2'd0, 8'h00); idle(2 * CD);
        rd(2'd2, v); chk("R10 cancelled reload", v, 2);
        ticks(2);
        chk("R11 pg pulse on", int'(pg_drop_o), 1);
        chk("R11 kbd stays low", int'(kbd_rst_o), 0);

        // R2 high byte
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R2 high byte", v, 1);
        rd(2'd2, v); chk("R2 low byte kept", v, 3);
        idle(PL + 2);

        // R12 narrow variant
        @(negedge clk); b_wr = 1; b_addr = 2'd3; b_wdata = 8'h12;
        @(negedge clk); b_wr = 0;
        @(negedge clk); b_wr = 1; b_addr = 2'd2; b_wdata = 8'h34;
        @(negedge clk); b_wr = 0;
        @(negedge clk); b_rd = 1; b_addr = 2'd3;
        @(negedge clk); b_rd = 0;
        chk("R12 high byte reads 0", int'(b_rdata), 0);
        @(negedge clk); b_rd = 1; b_addr = 2'd2;
        @(negedge clk); b_rd = 0;
        chk("R12 low byte", int'(b_rdata), 'h34);
        chk("R12 no expiry", int'(b_fired), 0);

        idle(2);
        finish_run();
    end
endmodule